// File: doc/BRIEF.md
# Serial Line Transmitter with Break Generation

This block turns characters taken from a transmit queue into an asynchronous serial stream on a single output line. Each character is framed by one low start bit and one or two high stop bits. It carries seven or eight data bits, least significant first, and can take an optional parity bit. Bit timing comes from an external oversampling strobe, and every bit lasts a fixed number of strobes. A character is taken from the queue only at a character boundary, and only when the far end permits it. The far end permits it through a clear-to-send input, which can also be forced on.

A break request holds the line low for as long as the request stays present. The transmitter never cuts a character short to send a break. It finishes the frame in progress, then drives the line low. When the request is withdrawn, it sends two full high bit periods before taking the next character. Characters queued during the break wait in the queue. Two enables, a global one and a transmitter one, each abandon any activity at once and park the line high.

Top module: `uart_tx_brk`

## Requirements
- R1: While reset is asserted and after reset is released, `txd` is 1, `busy` is 0 and `fifo_pop` is 0, until a character or break is started.
- R2: A frame is a start bit (0), the data bits LSB first, an optional parity bit, then stop bits (1). Each bit lasts exactly TICKS_PER_BIT (16) `baud_tick` strobes. The line is 1 whenever no frame, break or mark period is in progress. `busy` is 1 exactly while a frame, break or mark period is in progress.
- R3: With `word_long`=1, eight data bits `fifo_data[7:0]` are sent. With `word_long`=0, seven bits `fifo_data[6:0]` are sent and `fifo_data[7]` has no effect on the line.
- R4: With `par_en`=1, one parity bit follows the data. With `par_odd`=0 the total count of ones in data plus parity is even, and with `par_odd`=1 it is odd. With `par_en`=0, no parity bit is sent and `par_odd` has no effect.
- R5: With `two_stop`=1, two stop bit periods end the frame; otherwise one.
- R6: `fifo_pop` is 1 for exactly the single clock in which a character is taken. That happens only when the block is idle, both enables are 1, `brk_req` is 0, `fifo_valid` is 1, and `cts_in`=1 or `cts_force`=1. One clock after the pop, the start bit is on the line.
- R7: `brk_req` is examined at the end of each bit period and, while idle, on every clock. If it is 1 at the end of the last stop bit (or while idle), the line goes low and stays low through every bit period whose end finds `brk_req` at 1. The first bit end that finds it at 0 starts exactly two high bit periods, and then the block returns to idle.
- R8: During a frame, a `brk_req` pulse that is not present at any bit end has no effect on the line.
- R9: Characters presented while a break or its mark periods run are not popped; they are sent after the two mark periods end.
- R10: When `glb_en` is 0, at the next clock the block is idle with `txd`=1. A character in flight is dropped and is not resent.
- R11: When `tx_en` is 0, at the next clock the block is idle with `txd`=1. A character in flight is dropped and is not resent.
- R12: Word length, parity enable, parity sense and stop count are captured when a character is popped. Changing them mid-frame does not alter the frame in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | Oversampling strobe, one clock wide |
| glb_en | input | 1 | Global enable |
| tx_en | input | 1 | Transmitter enable |
| brk_req | input | 1 | Break request level |
| two_stop | input | 1 | 1 = two stop bits |
| word_long | input | 1 | 1 = 8-bit characters, 0 = 7-bit |
| par_en | input | 1 | Parity bit enable |
| par_odd | input | 1 | Parity sense, 1 = odd |
| cts_in | input | 1 | Clear-to-send from far end (active level set by CTS_ACTIVE_LOW, default high) |
| cts_force | input | 1 | Treat clear-to-send as always asserted |
| fifo_valid | input | 1 | Queue holds a character |
| fifo_data | input | DATA_W (8) | Head-of-queue character |
| fifo_pop | output | 1 | Takes the head character this clock |
| txd | output | 1 | Serial line |
| busy | output | 1 | Frame, break or mark period in progress |

## Verification
The bench targets break requests that arrive mid-character. A design that cut the frame short would lower the line early, and one that skipped or doubled the mark periods would take the next character at the wrong clock. Brief break pulses between bit ends must leave the frame untouched, and queued characters must stay unpopped until the marks finish. Aborts through either enable must park the line high and drop the character. Mid-frame changes to word length, parity and stop count must not reshape the frame already started. An engine that read those controls live would emit a frame of the wrong length. Blocked clear-to-send, forced clear-to-send and 7-bit characters with bit 7 set are also covered, since a wrong gate or mask there shows up as an early pop or a flipped bit.

// File: rtl/uart_tx_brk_pkg.sv
package uart_tx_brk_pkg;

   // Sequencer states; encoding order carries no meaning.
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PARITY,
      ST_STOP,
      ST_BREAK,
      ST_MARK
   } tx_state_e;

   // Frame options captured at the moment a character is taken.
   typedef struct packed {
      logic two_stop;
      logic par_en;
      logic par_bit;
   } frame_cfg_t;

endpackage

// File: rtl/utx_bit_timer.sv
module utx_bit_timer #(
   parameter int TICKS_PER_BIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic baud_tick,
   output logic bit_end
);
   localparam int CNT_W = (TICKS_PER_BIT > 2) ? $clog2(TICKS_PER_BIT) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_BIT - 1);

   logic [CNT_W-1:0] cnt;

   assign bit_end = run && baud_tick && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run) begin
         cnt <= '0;
      end else if (baud_tick) begin
         cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      end
   end

   initial begin : p_param_chk
      assert (TICKS_PER_BIT >= 2) else $error("TICKS_PER_BIT must be at least 2");
   end
endmodule

// File: rtl/utx_frame_shaper.sv
module utx_frame_shaper #(
   parameter int DATA_W = 8,
   localparam int IDX_W = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] raw_data,
   input  logic              word_long,
   input  logic              par_odd,
   output logic [DATA_W-1:0] shaped_data,
   output logic              par_bit,
   output logic [IDX_W-1:0]  last_idx
);
   // The top data bit exists only for long words; it is masked otherwise.
   for (genvar i = 0; i < DATA_W; i++) begin : g_mask
      if (i == DATA_W - 1) begin : g_top
         assign shaped_data[i] = raw_data[i] & word_long;
      end else begin : g_low
         assign shaped_data[i] = raw_data[i];
      end
   end

   assign par_bit  = (^shaped_data) ^ par_odd;
   assign last_idx = word_long ? IDX_W'(DATA_W - 1) : IDX_W'(DATA_W - 2);

   initial begin : p_param_chk
      assert (DATA_W >= 2) else $error("DATA_W must be at least 2");
   end
endmodule

// File: rtl/utx_flow_gate.sv
module utx_flow_gate #(
   parameter bit CTS_ACTIVE_LOW = 1'b0
) (
   input  logic cts_in,
   input  logic cts_force,
   output logic flow_ok
);
   if (CTS_ACTIVE_LOW) begin : g_low
      assign flow_ok = cts_force | ~cts_in;
   end else begin : g_high
      assign flow_ok = cts_force | cts_in;
   end
endmodule

// File: rtl/utx_seq.sv
module utx_seq
   import uart_tx_brk_pkg::*;
#(
   parameter int DATA_W = 8,
   localparam int IDX_W = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              brk_req,
   input  logic              flow_ok,
   input  logic              fifo_valid,
   input  logic [DATA_W-1:0] load_data,
   input  logic [IDX_W-1:0]  load_last,
   input  frame_cfg_t        load_cfg,
   input  logic              bit_end,
   output logic              fifo_pop,
   output logic              txd,
   output logic              busy
);
   tx_state_e         st;
   logic [DATA_W-1:0] shreg;
   logic [IDX_W-1:0]  idx;
   logic [IDX_W-1:0]  last_q;
   frame_cfg_t        cfg_q;
   logic              second;
   logic              take;

   assign take     = (st == ST_IDLE) && active && !brk_req && fifo_valid && flow_ok;
   assign fifo_pop = take;
   assign busy     = (st != ST_IDLE);

   always_comb begin
      unique case (st)
         ST_START, ST_BREAK: txd = 1'b0;
         ST_DATA:            txd = shreg[0];
         ST_PARITY:          txd = cfg_q.par_bit;
         default:            txd = 1'b1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         shreg  <= '0;
         idx    <= '0;
         last_q <= '0;
         cfg_q  <= '0;
         second <= 1'b0;
      end else if (!active) begin
         st     <= ST_IDLE;
         second <= 1'b0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (brk_req) begin
                  st <= ST_BREAK;
               end else if (take) begin
                  shreg  <= load_data;
                  last_q <= load_last;
                  cfg_q  <= load_cfg;
                  st     <= ST_START;
               end
            end
            ST_START: begin
               if (bit_end) begin
                  idx <= '0;
                  st  <= ST_DATA;
               end
            end
            ST_DATA: begin
               if (bit_end) begin
                  shreg <= shreg >> 1;
                  if (idx == last_q) begin
                     second <= 1'b0;
                     st     <= cfg_q.par_en ? ST_PARITY : ST_STOP;
                  end else begin
                     idx <= idx + 1'b1;
                  end
               end
            end
            ST_PARITY: begin
               if (bit_end) st <= ST_STOP;
            end
            ST_STOP: begin
               if (bit_end) begin
                  if (cfg_q.two_stop && !second) begin
                     second <= 1'b1;
                  end else begin
                     second <= 1'b0;
                     st     <= brk_req ? ST_BREAK : ST_IDLE;
                  end
               end
            end
            ST_BREAK: begin
               if (bit_end && !brk_req) begin
                  second <= 1'b0;
                  st     <= ST_MARK;
               end
            end
            ST_MARK: begin
               if (bit_end) begin
                  if (!second) begin
                     second <= 1'b1;
                  end else begin
                     second <= 1'b0;
                     st     <= ST_IDLE;
                  end
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   AST_POP_STARTS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop |=> (st == ST_START && !txd)); // R6

   AST_BREAK_RELEASE_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_BREAK && active && bit_end && !brk_req) |=> (st == ST_MARK && txd)); // R7

   AST_STOP_INTO_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_STOP && active && bit_end && brk_req && (!cfg_q.two_stop || second))
      |=> (st == ST_BREAK && !txd)); // R7
endmodule

// File: rtl/uart_tx_brk.sv
module uart_tx_brk
   import uart_tx_brk_pkg::*;
#(
   parameter int DATA_W         = 8,
   parameter int TICKS_PER_BIT  = 16,
   parameter bit CTS_ACTIVE_LOW = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              glb_en,
   input  logic              tx_en,
   input  logic              brk_req,
   input  logic              two_stop,
   input  logic              word_long,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              cts_in,
   input  logic              cts_force,
   input  logic              fifo_valid,
   input  logic [DATA_W-1:0] fifo_data,
   output logic              fifo_pop,
   output logic              txd,
   output logic              busy
);
   localparam int IDX_W = $clog2(DATA_W);

   logic              active;
   logic              flow_ok;
   logic              bit_end;
   logic [DATA_W-1:0] shaped;
   logic              par_bit;
   logic [IDX_W-1:0]  last_idx;
   frame_cfg_t        cfg_now;

   assign active  = glb_en && tx_en;
   assign cfg_now = '{two_stop: two_stop, par_en: par_en, par_bit: par_bit};

   utx_flow_gate #(.CTS_ACTIVE_LOW(CTS_ACTIVE_LOW)) u_flow (
      .cts_in    (cts_in),
      .cts_force (cts_force),
      .flow_ok   (flow_ok)
   );

   utx_frame_shaper #(.DATA_W(DATA_W)) u_shape (
      .raw_data    (fifo_data),
      .word_long   (word_long),
      .par_odd     (par_odd),
      .shaped_data (shaped),
      .par_bit     (par_bit),
      .last_idx    (last_idx)
   );

   utx_bit_timer #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (busy),
      .baud_tick (baud_tick),
      .bit_end   (bit_end)
   );

   utx_seq #(.DATA_W(DATA_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .active     (active),
      .brk_req    (brk_req),
      .flow_ok    (flow_ok),
      .fifo_valid (fifo_valid),
      .load_data  (shaped),
      .load_last  (last_idx),
      .load_cfg   (cfg_now),
      .bit_end    (bit_end),
      .fifo_pop   (fifo_pop),
      .txd        (txd),
      .busy       (busy)
   );

   AST_POP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop |-> (fifo_valid && glb_en && tx_en && !brk_req
                    && (cts_force || (cts_in ^ CTS_ACTIVE_LOW)))); // R6

   AST_NO_POP_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !fifo_pop); // R9

   AST_GLB_OFF_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
      !glb_en |=> (!busy && txd)); // R10

   AST_TX_OFF_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |=> (!busy && txd)); // R11

   AST_TXD_HOLDS_MIDBIT: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !$past(baud_tick)) |-> $stable(txd)); // R2

   initial begin : p_param_chk
      assert (DATA_W >= 2) else $error("DATA_W must be at least 2");
      assert (TICKS_PER_BIT >= 2) else $error("TICKS_PER_BIT must be at least 2");
   end
endmodule

// File: tb/uart_tx_brk_tb.sv
module uart_tx_brk_tb;
   localparam int CLK_PERIOD = 10;
   localparam int TPB        = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic baud_tick = 1'b0;
   logic glb_en = 1'b0, tx_en = 1'b0, brk_req = 1'b0;
   logic two_stop = 1'b0, word_long = 1'b1, par_en = 1'b0, par_odd = 1'b0;
   logic cts_in = 1'b1, cts_force = 1'b0;
   logic fifo_valid = 1'b0;
   logic [7:0] fifo_data = 8'h00;
   logic fifo_pop, txd, busy;

   always #(CLK_PERIOD/2) clk = ~clk;

   uart_tx_brk u_dut (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .glb_en(glb_en), .tx_en(tx_en),
      .brk_req(brk_req), .two_stop(two_stop), .word_long(word_long), .par_en(par_en),
      .par_odd(par_odd), .cts_in(cts_in), .cts_force(cts_force), .fifo_valid(fifo_valid),
      .fifo_data(fifo_data), .fifo_pop(fifo_pop), .txd(txd), .busy(busy)
   );

   int n_cmp = 0;
   int n_bad = 0;
   string cur_req = "R1";
   byte unsigned fq[$];
   bit popped = 1'b0;
   int cyc = 0;
   bit done = 1'b0;

   // Queue and strobe driver: updates after the checker has sampled.
   always @(posedge clk) if (fifo_pop) popped = 1'b1;
   always @(negedge clk) begin
      #2;
      cyc++;
      baud_tick = (cyc % 5) != 2;
      if (popped && fq.size() > 0) void'(fq.pop_front());
      popped = 1'b0;
      fifo_valid = fq.size() > 0;
      fifo_data  = (fq.size() > 0) ? fq[0] : 8'h00;
   end

   // Reference model: 0 idle, 1 frame, 2 break, 3 marks.
   int m_mode = 0, m_tk = 0, m_marks = 0;
   bit m_bits[$];

   function automatic bit m_active();
      return glb_en && tx_en;
   endfunction
   function automatic bit m_pop();
      return m_mode == 0 && m_active() && !brk_req && fifo_valid && (cts_in || cts_force);
   endfunction
   function automatic bit m_txd();
      if (m_mode == 1) return m_bits[0];
      if (m_mode == 2) return 1'b0;
      return 1'b1;
   endfunction

   always @(posedge clk) begin
      if (!rst_n || !m_active()) begin
         m_mode = 0; m_tk = 0; m_bits.delete();
      end else begin
         case (m_mode)
            0: begin
               if (brk_req) begin
                  m_mode = 2; m_tk = 0;
               end else if (m_pop()) begin
                  int n;
                  int ones;
                  n = word_long ? 8 : 7;
                  ones = 0;
                  m_bits.delete();
                  m_bits.push_back(1'b0);
                  for (int i = 0; i < n; i++) begin
                     m_bits.push_back(fifo_data[i]);
                     ones += fifo_data[i];
                  end
                  if (par_en) m_bits.push_back(((ones % 2) == 1) ^ par_odd);
                  m_bits.push_back(1'b1);
                  if (two_stop) m_bits.push_back(1'b1);
                  m_mode = 1; m_tk = 0;
               end
            end
            1: if (baud_tick) begin
               if (m_tk == TPB - 1) begin
                  m_tk = 0;
                  void'(m_bits.pop_front());
                  if (m_bits.size() == 0) m_mode = brk_req ? 2 : 0;
               end else m_tk++;
            end
            2: if (baud_tick) begin
               if (m_tk == TPB - 1) begin
                  m_tk = 0;
                  if (!brk_req) begin m_mode = 3; m_marks = 2; end
               end else m_tk++;
            end
            default: if (baud_tick) begin
               if (m_tk == TPB - 1) begin
                  m_tk = 0;
                  m_marks--;
                  if (m_marks == 0) m_mode = 0;
               end else m_tk++;
            end
         endcase
      end
   end

   task automatic chk(string what, logic act, logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s at cycle %0d: actual=%b expected=%b", cur_req, what, cyc, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("txd", txd, m_txd());
         chk("busy", busy, m_mode != 0);
         chk("fifo_pop", fifo_pop, m_pop());
      end
   end

   task automatic wait_clk(int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 20000; i++) begin
         @(negedge clk);
         if (!busy && fq.size() == 0) break;
      end
      wait_clk(20);
   endtask

   task automatic direct(string what, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", cur_req, what, act, exp);
      end
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      // R1: reset values
      wait_clk(3);
      direct("txd in reset", txd, 1);
      direct("busy in reset", busy, 0);
      rst_n = 1'b1;
      wait_clk(2);
      direct("txd after reset", txd, 1);
      direct("pop after reset", fifo_pop, 0);
      glb_en = 1'b1; tx_en = 1'b1;
      wait_clk(5);

      cur_req = "R2"; word_long = 1'b1;
      fq.push_back(8'hA5); wait_idle();

      cur_req = "R3"; word_long = 1'b0;
      fq.push_back(8'hC3); fq.push_back(8'h7F); wait_idle();
      word_long = 1'b1;

      cur_req = "R4"; par_en = 1'b1; par_odd = 1'b0;
      fq.push_back(8'h5A); fq.push_back(8'h03); wait_idle();
      par_odd = 1'b1;
      fq.push_back(8'h5A); fq.push_back(8'h03); wait_idle();
      par_en = 1'b0;
      fq.push_back(8'h81); wait_idle();
      par_odd = 1'b0;

      cur_req = "R5"; two_stop = 1'b1;
      fq.push_back(8'h3C); fq.push_back(8'hE1); wait_idle();
      two_stop = 1'b0;

      cur_req = "R6"; cts_in = 1'b0;
      fq.push_back(8'h66); wait_clk(300);
      direct("busy while flow blocked", busy, 0);
      direct("queue held while flow blocked", fq.size(), 1);
      cts_force = 1'b1; wait_idle();
      cts_force = 1'b0; cts_in = 1'b1;

      cur_req = "R7";
      fq.push_back(8'h11); fq.push_back(8'h22); fq.push_back(8'h33);
      wait_clk(40); brk_req = 1'b1;
      wait_clk(1500);
      direct("line low in break", txd, 0);
      cur_req = "R9";
      direct("queued chars held in break", fq.size(), 2);
      brk_req = 1'b0;
      wait_idle();

      cur_req = "R8";
      fq.push_back(8'h44); wait_clk(63);
      brk_req = 1'b1; wait_clk(1); brk_req = 1'b0;
      wait_idle();

      cur_req = "R7";
      brk_req = 1'b1; wait_clk(100); brk_req = 1'b0; wait_idle();

      cur_req = "R10";
      fq.push_back(8'h55); fq.push_back(8'h56);
      wait_clk(100); glb_en = 1'b0;
      wait_clk(3);
      direct("busy after global off", busy, 0);
      direct("txd after global off", txd, 1);
      glb_en = 1'b1; wait_idle();

      cur_req = "R11";
      fq.push_back(8'h77); wait_clk(100); tx_en = 1'b0;
      wait_clk(3);
      direct("busy after tx off", busy, 0);
      direct("txd after tx off", txd, 1);
      tx_en = 1'b1; wait_idle();

      cur_req = "R12";
      fq.push_back(8'h9C); wait_clk(50);
      word_long = 1'b0; par_en = 1'b1; two_stop = 1'b1; par_odd = 1'b1;
      wait_idle();
      word_long = 1'b1; par_en = 1'b0; two_stop = 1'b0; par_odd = 1'b0;
      wait_clk(10);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule